// File: doc/BRIEF.md
# Dual-Clock FIFO with Mark and Retransmit

This block is a first-in first-out buffer between two independent clock domains. A producer writes words on the write clock and a consumer reads them on the read clock. The write side has two active-low qualifiers, an enable and a chip select, and a word is stored only when both are low. The read side has an active-low enable and an active-low chip select. The chip select also drives an output-enable signal that a pad ring can use to tri-state the data bus.

The consumer can record its current read position with a mark pulse. It can later rewind to that position, or to the first memory location if no mark was recorded since reset, with a retransmit pulse. Rewinding moves only the read pointer. Data already written stays in place, and the write side carries on where it was.

Each port has a static rate strap. In single-rate mode one word moves per rising edge. In double-rate mode an accepted transfer moves two words: one on the rising edge and one on the following falling edge. The full and empty flags then count in pairs. Pointers cross between the domains as Gray codes through two-stage synchronizers.

Top module: `rtf_fifo`

## Requirements
- R1: A word is written only at a rising write-clock edge where `wen_n` and `wcs_n` are both low and `full` is low. If either qualifier is high, nothing is stored.
- R2: A read is accepted at a rising read-clock edge where `ren_n` and `rcs_n` are both low and `empty` is low. Words come out in the order they were written, and `q` shows the oldest unread word after that edge.
- R3: `q_oe` is high while `rst_n` is low, whatever `rcs_n` is. After reset, `q_oe` equals the inverse of `rcs_n` sampled at the previous rising read edge. A high `rcs_n` also blocks the read.
- R4: With a port's rate strap low (single rate), each accepted transfer on that port moves exactly one word, on the rising edge.
- R5: With `wr_ddr` high, a write accepted at a rising edge stores the word on `din` at that edge and then the word on `din` at the next falling edge, in that order.
- R6: With `rd_ddr` high, an accepted read shows the first word of the pair on `q` while `rclk` is high after the edge. It shows the second word after the following falling edge. The read pointer advances by two.
- R7: `full` is high when fewer free locations remain than one transfer needs: 1 in single rate, 2 in double rate, with depth 2^AW. With AW=4 and no reads, single rate asserts `full` after exactly 16 words, and double rate after 8 pairs. A write attempted while `full` is high is discarded.
- R8: `empty` is high when fewer unread words are visible to the read side than one read transfer needs.
- R9: A `rt` pulse at a rising read edge with no read accepted in that cycle loads the read pointer from the mark register. Reading then repeats the data from that position.
- R10: A `mark` pulse at a rising read edge stores the current read pointer in the mark register. Reset clears the mark register to 0, so a retransmit with no earlier mark restarts at the first location.
- R11: In the read cycle right after an accepted retransmit, `empty` is high.
- R12: A retransmit leaves the write pointer alone. Words written afterwards follow the words already written.
- R13: A `rt` pulse in the same cycle as an accepted read is ignored. The read proceeds and the read pointer is not rewound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_ddr | input | 1 | Write-side rate strap, 1 = double rate; static while out of reset |
| rd_ddr | input | 1 | Read-side rate strap, 1 = double rate; static while out of reset |
| din | input | DW | Write data |
| wen_n | input | 1 | Active-low write enable |
| wcs_n | input | 1 | Active-low write chip select, a second write qualifier |
| full | output | 1 | No room for one more write transfer |
| ren_n | input | 1 | Active-low read enable |
| rcs_n | input | 1 | Active-low read chip select; gates reads and drives `q_oe` |
| rt | input | 1 | Retransmit: rewind the read pointer to the mark |
| mark | input | 1 | Store the current read pointer as the mark |
| q | output | DW | Read data |
| q_oe | output | 1 | Output enable for the read data bus |
| empty | output | 1 | Not enough data for one read transfer |

## Verification
The assertions take for granted that both rate straps change only while `rst_n` is low. They also assume every input is driven away from the clock edge that samples it, and that the write side never laps the retained region that a retransmit returns to. The bench changes straps only inside a reset and changes double-rate write data a quarter period after the rising edge. It keeps the total amount written below the depth between rewinds, so the retained words are never overwritten before they are read again.

// File: rtl/rtf_pkg.sv
package rtf_pkg;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s << 1) b = b ^ (b >> s);
    return b;
  endfunction

  // words moved by one transfer
  function automatic logic [31:0] step_of(input logic pair);
    return pair ? 32'd2 : 32'd1;
  endfunction

  // in pair mode the pointer is even, so the pair count is what crosses
  function automatic logic [31:0] ptr_encode(input logic [31:0] p, input logic pair);
    return to_gray(pair ? (p >> 1) : p);
  endfunction

  function automatic logic [31:0] ptr_decode(input logic [31:0] g, input logic pair);
    return pair ? (from_gray(g) << 1) : from_gray(g);
  endfunction

endpackage

// File: rtl/rtf_sync.sv
module rtf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rtf_mem.sv
module rtf_mem #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          wclk,
  input  logic          we0,
  input  logic          we1,
  input  logic [AW-1:0] wa0,
  input  logic [AW-1:0] wa1,
  input  logic [DW-1:0] wd0,
  input  logic [DW-1:0] wd1,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [DW-1:0] rq0,
  output logic [DW-1:0] rq1
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we0) cells[wa0] <= wd0;
    if (we1) cells[wa1] <= wd1;
  end

  assign rq0 = cells[ra0];
  assign rq1 = cells[ra1];
endmodule

// File: rtl/rtf_wr.sv
module rtf_wr
  import rtf_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          ddr,
  input  logic          rd_ddr,
  input  logic          wen_n,
  input  logic          wcs_n,
  input  logic [DW-1:0] din,
  input  logic [AW:0]   rgray_s,
  output logic          full,
  output logic          accept,
  output logic [AW:0]   wgray,
  output logic          mem_we0,
  output logic          mem_we1,
  output logic [AW-1:0] mem_a0,
  output logic [AW-1:0] mem_a1,
  output logic [DW-1:0] mem_d0,
  output logic [DW-1:0] mem_d1
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wptr, rview, rprev, hold_a, used, room_lim;
  logic [DW-1:0] hold_r, hold_f;
  logic          pend;

  assign used     = wptr - rview;
  assign room_lim = PW'(DEPTH) - PW'(step_of(ddr));
  assign full     = used > room_lim;
  assign accept   = !wen_n && !wcs_n && !full;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      rview  <= '0;
      rprev  <= '0;
      wgray  <= '0;
      hold_a <= '0;
      hold_r <= '0;
      pend   <= 1'b0;
    end else begin
      // take the read pointer only when two samples agree (rewind is a jump)
      rprev <= rgray_s;
      if (rgray_s == rprev) rview <= PW'(ptr_decode(32'(rgray_s), rd_ddr));
      if (ddr) begin
        if (pend) wgray <= PW'(ptr_encode(32'(hold_a + PW'(2)), 1'b1));
        pend <= accept;
        if (accept) begin
          hold_r <= din;
          hold_a <= wptr;
          wptr   <= wptr + PW'(2);
        end
      end else if (accept) begin
        wptr  <= wptr + PW'(1);
        wgray <= PW'(ptr_encode(32'(wptr + PW'(1)), 1'b0));
      end
    end
  end

  // second word of a double-rate pair
  always_ff @(negedge wclk or negedge rst_n) begin
    if (!rst_n)    hold_f <= '0;
    else if (pend) hold_f <= din;
  end

  assign mem_we0 = ddr ? pend : accept;
  assign mem_we1 = ddr && pend;
  assign mem_a0  = ddr ? hold_a[AW-1:0] : wptr[AW-1:0];
  assign mem_a1  = mem_a0 + AW'(1);
  assign mem_d0  = ddr ? hold_r : din;
  assign mem_d1  = hold_f;
endmodule

// File: rtl/rtf_rd.sv
module rtf_rd
  import rtf_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ddr,
  input  logic          wr_ddr,
  input  logic          ren_n,
  input  logic          rcs_n,
  input  logic          rt,
  input  logic          mark,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_q0,
  input  logic [DW-1:0] mem_q1,
  output logic [AW-1:0] mem_a0,
  output logic [AW-1:0] mem_a1,
  output logic [DW-1:0] q,
  output logic          q_oe,
  output logic          empty,
  output logic [AW:0]   rgray,
  output logic [AW:0]   rptr,
  output logic [AW:0]   mark_q,
  output logic          rd_fire,
  output logic          rt_fire
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wview, avail, rptr_nxt;
  logic [DW-1:0] q_a, q_b, q_f;
  logic          rt_hold, tog_p, tog_n, sel;

  assign wview   = PW'(ptr_decode(32'(wgray_s), wr_ddr));
  assign avail   = wview - rptr;
  assign empty   = (avail < PW'(step_of(ddr))) || rt_hold;
  assign rd_fire = !ren_n && !rcs_n && !empty;
  assign rt_fire = rt && !rd_fire;

  always_comb begin
    rptr_nxt = rptr;
    if (rt_fire)      rptr_nxt = mark_q;
    else if (rd_fire) rptr_nxt = rptr + PW'(step_of(ddr));
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr    <= '0;
      rgray   <= '0;
      mark_q  <= '0;
      rt_hold <= 1'b0;
      q_a     <= '0;
      q_b     <= '0;
      q_oe    <= 1'b1;
      tog_p   <= 1'b0;
    end else begin
      rptr    <= rptr_nxt;
      rgray   <= PW'(ptr_encode(32'(rptr_nxt), ddr));
      rt_hold <= rt_fire;
      q_oe    <= !rcs_n;
      tog_p   <= !tog_p;
      if (mark) mark_q <= rptr;
      if (rd_fire) begin
        q_a <= mem_q0;
        q_b <= mem_q1;
      end
    end
  end

  always_ff @(negedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      tog_n <= 1'b0;
      q_f   <= '0;
    end else begin
      tog_n <= tog_p;
      q_f   <= q_b;
    end
  end

  // sel is high in the half period after a rising edge
  assign sel    = tog_p ^ tog_n;
  assign q      = (ddr && !sel) ? q_f : q_a;
  assign mem_a0 = rptr[AW-1:0];
  assign mem_a1 = mem_a0 + AW'(1);
endmodule

// File: rtl/rtf_fifo.sv
module rtf_fifo #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_ddr,
  input  logic          rd_ddr,
  input  logic [DW-1:0] din,
  input  logic          wen_n,
  input  logic          wcs_n,
  output logic          full,
  input  logic          ren_n,
  input  logic          rcs_n,
  input  logic          rt,
  input  logic          mark,
  output logic [DW-1:0] q,
  output logic          q_oe,
  output logic          empty
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s, rptr, mark_q;
  logic          wr_accept, rd_fire, rt_fire;
  logic          we0, we1;
  logic [AW-1:0] wa0, wa1, ra0, ra1;
  logic [DW-1:0] wd0, wd1, rq0, rq1;

  rtf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  rtf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  rtf_wr #(.AW(AW), .DW(DW)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .ddr(wr_ddr), .rd_ddr(rd_ddr),
    .wen_n(wen_n), .wcs_n(wcs_n), .din(din), .rgray_s(rgray_s),
    .full(full), .accept(wr_accept), .wgray(wgray),
    .mem_we0(we0), .mem_we1(we1), .mem_a0(wa0), .mem_a1(wa1),
    .mem_d0(wd0), .mem_d1(wd1)
  );

  rtf_mem #(.AW(AW), .DW(DW)) u_mem (
    .wclk(wclk), .we0(we0), .we1(we1), .wa0(wa0), .wa1(wa1),
    .wd0(wd0), .wd1(wd1), .ra0(ra0), .ra1(ra1), .rq0(rq0), .rq1(rq1)
  );

  rtf_rd #(.AW(AW), .DW(DW)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .ddr(rd_ddr), .wr_ddr(wr_ddr),
    .ren_n(ren_n), .rcs_n(rcs_n), .rt(rt), .mark(mark),
    .wgray_s(wgray_s), .mem_q0(rq0), .mem_q1(rq1),
    .mem_a0(ra0), .mem_a1(ra1), .q(q), .q_oe(q_oe), .empty(empty),
    .rgray(rgray), .rptr(rptr), .mark_q(mark_q),
    .rd_fire(rd_fire), .rt_fire(rt_fire)
  );
endmodule

// File: rtl/rtf_chk.sv
module rtf_chk #(
  parameter int AW = 4
) (
  input logic        wclk,
  input logic        rclk,
  input logic        rst_n,
  input logic        wr_ddr,
  input logic        rd_ddr,
  input logic        wen_n,
  input logic        wcs_n,
  input logic        rcs_n,
  input logic        mark,
  input logic        q_oe,
  input logic        empty,
  input logic [AW:0] wgray,
  input logic [AW:0] rptr,
  input logic [AW:0] mark_q,
  input logic        rd_fire,
  input logic        rt_fire
);
  localparam int PW = AW + 1;

  // R9
  rt_rewind_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rt_fire |=> rptr == $past(mark_q))
    else $error("retransmit did not load the mark");

  // R11
  rt_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rt_fire |=> empty)
    else $error("empty low right after retransmit");

  // R10
  mark_capture_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    mark |=> mark_q == $past(rptr))
    else $error("mark did not capture the read pointer");

  // R3
  cs_off_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rcs_n |=> !q_oe)
    else $error("output enabled with chip select high");

  // R3
  cs_on_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !rcs_n |=> q_oe)
    else $error("output disabled with chip select low");

  // R4
  read_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_fire |=> rptr == PW'($past(rptr) + PW'(rd_ddr ? 2 : 1)))
    else $error("read pointer step wrong");

  // R1
  wr_gate_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wr_ddr && (wen_n || wcs_n)) |=> $stable(wgray))
    else $error("write pointer moved without both qualifiers");
endmodule

bind rtf_fifo rtf_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_ddr(wr_ddr), .rd_ddr(rd_ddr),
  .wen_n(wen_n), .wcs_n(wcs_n), .rcs_n(rcs_n), .mark(mark), .q_oe(q_oe),
  .empty(empty), .wgray(wgray), .rptr(rptr), .mark_q(mark_q),
  .rd_fire(rd_fire), .rt_fire(rt_fire)
);

// File: tb/tb_rtf_fifo.sv
module tb_rtf_fifo;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_ddr = 1'b0, rd_ddr = 1'b0;
  logic [DW-1:0] din = '0;
  logic wen_n = 1'b1, wcs_n = 1'b1, ren_n = 1'b1, rcs_n = 1'b0, rt = 1'b0, mark = 1'b0;
  logic full, q_oe, empty;
  logic [DW-1:0] q;

  int n_checks = 0, n_fail = 0;
  logic [DW-1:0] hist[$];
  int rd_idx = 0, mark_idx = 0;

  rtf_fifo #(.DW(DW), .AW(AW)) dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_ddr(wr_ddr), .rd_ddr(rd_ddr),
    .din(din), .wen_n(wen_n), .wcs_n(wcs_n), .full(full), .ren_n(ren_n),
    .rcs_n(rcs_n), .rt(rt), .mark(mark), .q(q), .q_oe(q_oe), .empty(empty)
  );

  always #(CLK_PERIOD/2)  wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int want(input int idx);
    return (idx < hist.size()) ? int'(hist[idx]) : -1;
  endfunction

  task automatic settle();
    repeat (6) @(posedge rclk);
    repeat (6) @(posedge wclk);
  endtask

  task automatic do_reset(input logic wd, input logic rd);
    rst_n = 1'b0; wr_ddr = wd; rd_ddr = rd; rcs_n = 1'b1;
    wen_n = 1'b1; wcs_n = 1'b0; ren_n = 1'b1; rt = 1'b0; mark = 1'b0;
    hist.delete(); rd_idx = 0; mark_idx = 0;
    repeat (3) @(posedge wclk);
    #1;
    chk("R3 q_oe high in reset with rcs_n high", int'(q_oe), 1);
    chk("R8 empty in reset", int'(empty), 1);
    chk("R7 full low in reset", int'(full), 0);
    rcs_n = 1'b0;
    @(negedge wclk) rst_n = 1'b1;
    settle();
  endtask

  task automatic wr1(input logic [DW-1:0] d);
    logic ok;
    @(negedge wclk);
    din = d; wen_n = 1'b0; wcs_n = 1'b0; ok = !full;
    @(posedge wclk);
    #1 wen_n = 1'b1;
    if (ok) hist.push_back(d);
  endtask

  task automatic wr_pair(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic ok;
    @(negedge wclk);
    din = a; wen_n = 1'b0; wcs_n = 1'b0; ok = !full;
    @(posedge wclk);
    #(CLK_PERIOD/4) din = b; wen_n = 1'b1;
    @(negedge wclk);
    #1;
    if (ok) begin hist.push_back(a); hist.push_back(b); end
  endtask

  task automatic wait_data();
    int tries = 0;
    @(negedge rclk);
    while (empty && tries < 200) begin @(negedge rclk); tries++; end
  endtask

  task automatic rd_one(input string tag);
    wait_data();
    ren_n = 1'b0;
    @(posedge rclk);
    #1 ren_n = 1'b1;
    chk(tag, int'(q), want(rd_idx));
    rd_idx++;
  endtask

  task automatic rd_pair(input string tag);
    wait_data();
    ren_n = 1'b0;
    @(posedge rclk);
    #1 ren_n = 1'b1;
    chk({tag, " R6 rising half"}, int'(q), want(rd_idx));
    @(negedge rclk);
    #1 chk({tag, " R6 falling half"}, int'(q), want(rd_idx + 1));
    rd_idx += 2;
  endtask

  task automatic retransmit();
    @(negedge rclk) rt = 1'b1;
    @(posedge rclk);
    #1 rt = 1'b0;
    chk("R11 empty after retransmit", int'(empty), 1);
    rd_idx = mark_idx;
  endtask

  task automatic set_mark();
    @(negedge rclk) mark = 1'b1;
    @(posedge rclk);
    #1 mark = 1'b0;
    mark_idx = rd_idx;
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    // single rate on both ports
    do_reset(1'b0, 1'b0);

    // R1: one qualifier high at a time, nothing stored
    @(negedge wclk) din = 8'hAA; wen_n = 1'b0; wcs_n = 1'b1;
    @(negedge wclk) wen_n = 1'b1; wcs_n = 1'b0;
    settle();
    chk("R1 no write with a qualifier high", int'(empty), 1);

    // R2 R4 R8: plain traffic
    for (int i = 0; i < 5; i++) wr1(8'h10 + 8'(i));
    settle();
    chk("R8 empty low with data", int'(empty), 0);
    for (int i = 0; i < 5; i++) rd_one("R2 R4 in-order read");
    settle();
    chk("R8 empty after draining", int'(empty), 1);

    // R9 R10: retransmit with no mark restarts at location 0
    retransmit();
    settle();
    for (int i = 0; i < 5; i++) rd_one("R10 replay from first location");

    // R10: mark in the middle
    for (int i = 0; i < 4; i++) wr1(8'h30 + 8'(i));
    rd_one("R2 read before mark");
    rd_one("R2 read before mark");
    set_mark();
    rd_one("R2 read after mark");
    rd_one("R2 read after mark");
    retransmit();
    settle();
    rd_one("R9 replay from mark");
    rd_one("R9 replay from mark");
    settle();
    chk("R8 empty after replay", int'(empty), 1);

    // R12: retransmit then write more, new words follow old ones
    retransmit();
    wr1(8'h50);
    wr1(8'h51);
    for (int i = 0; i < 4; i++) rd_one("R12 writes append after rewind");

    // R13: retransmit together with a read is ignored
    wr1(8'h60);
    wr1(8'h61);
    settle();
    @(negedge rclk) ren_n = 1'b0; rt = 1'b1;
    @(posedge rclk);
    #1 ren_n = 1'b1; rt = 1'b0;
    chk("R13 read proceeds with rt", int'(q), want(rd_idx));
    rd_idx++;
    chk("R13 no rewind, no forced empty", int'(empty), 0);
    rd_one("R13 next word follows");

    // R3: chip select high blocks the read and drops q_oe
    wr1(8'h70);
    settle();
    @(negedge rclk) rcs_n = 1'b1; ren_n = 1'b0;
    @(posedge rclk);
    #1 chk("R3 q_oe low with rcs_n high", int'(q_oe), 0);
    ren_n = 1'b1; rcs_n = 1'b0;
    @(posedge rclk);
    #1 chk("R3 q_oe back high", int'(q_oe), 1);
    chk("R3 read gated by rcs_n", int'(empty), 0);
    rd_one("R3 word kept after gated read");

    // R7: fill in single rate
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      wr1(8'h80 + 8'(i));
      if (i == DEPTH - 2) chk("R7 not full one short", int'(full), 0);
    end
    chk("R7 full after 16 words", int'(full), 1);
    wr1(8'hEE);
    chk("R7 write while full dropped", hist.size(), DEPTH);
    settle();
    for (int i = 0; i < DEPTH; i++) rd_one("R7 data after fill");
    settle();
    chk("R7 no extra word stored", int'(empty), 1);
    chk("R7 full clears after reads", int'(full), 0);

    // R5 R6: double rate on both ports
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) wr_pair(8'hA0 + 8'(2*i), 8'hA1 + 8'(2*i));
    settle();
    for (int i = 0; i < 3; i++) rd_pair("R5");
    settle();
    chk("R8 double-rate empty", int'(empty), 1);

    do_reset(1'b1, 1'b1);
    for (int i = 0; i < DEPTH/2; i++) begin
      wr_pair(8'hC0 + 8'(2*i), 8'hC1 + 8'(2*i));
      if (i == DEPTH/2 - 2) chk("R7 double-rate not full at 14", int'(full), 0);
    end
    chk("R7 double-rate full at 8 pairs", int'(full), 1);
    wr_pair(8'hEE, 8'hEF);
    chk("R7 double-rate pair dropped", hist.size(), DEPTH);
    settle();
    for (int i = 0; i < DEPTH/2; i++) rd_pair("R7 double-rate drain");
    retransmit();
    settle();
    rd_pair("R9 double-rate replay");
    rd_pair("R9 double-rate replay");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule